// File: doc/BRIEF.md
# DMA Adapter Register Bank

This block is the register file of a DMA adapter that sits between a SCSI protocol controller and a system bus master. Software reaches it through a 16-bit register port with a 3-bit address. It stores the adapter's control word, a 32-bit transfer address, a 32-bit DMA length, a 32-bit FIFO byte count and an interrupt-vector word. Each 32-bit value is reached as two 16-bit halves.

The FIFO count goes down by one for every byte strobe while transfers are enabled. When it reaches zero it raises a sticky completion flag. Error pulses from the bus side set sticky flags. All pending conditions merge into one registered interrupt line. The protocol controller's own request is deliberately gated. It passes only while DMA is enabled, the FIFO is empty and the byte count is zero. Software therefore zeroes the counts and turns DMA on to hear reselection requests. The two reset controls in the control word are active low, so the block comes out of reset holding the FIFO and the SCSI controller in reset.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register reads 0. fifo_rst_out and scsi_rst_out are 1, dma_en_out and irq_out are 0.
- R2: Addresses are 0 control word, 1/2 transfer address high/low, 3/4 DMA length high/low, 5/6 FIFO count high/low, 7 vector word. Writes take effect at the clock edge. reg_rdata shows the register addressed at the previous edge.
- R3: A write to a FIFO count half also loads the same half of the DMA length. A write to a DMA length half leaves the FIFO count alone.
- R4: Control word bits are 0 FIFO release (active low reset), 1 SCSI release (active low reset), 2 interrupt enable, 3 DMA enable and 4 send direction. fifo_rst_out and scsi_rst_out are the inverse of bits 0 and 1. dma_en_out and send_out follow bits 3 and 4.
- R5: A byte strobe lowers the 32-bit FIFO count by one, borrowing across halves. This happens only while DMA is enabled, the FIFO is released and the count is nonzero. At zero the count stays at zero. A register write to the count in the same cycle wins over the strobe.
- R6: A strobe that takes the FIFO count from 1 to 0 sets the sticky DMA-done flag, read-only bit 9 of the control word.
- R7: A conflict pulse sets sticky read-only bit 10. A bus-error pulse sets sticky read-only bit 11. Read-only bit 8 mirrors the controller request, one cycle late.
- R8: While bit 0 is 0 (FIFO held in reset), bits 9 to 11 are cleared and stay clear.
- R9: irq_out is registered. It is 1 when interrupt enable is set and any of these holds: the done flag, either error flag, or a gated controller request.
- R10: A controller request is gated off while DMA enable is 0, while fifo_empty_in is 0, or while the FIFO count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| sbc_irq_in | input | 1 | Interrupt request from the SCSI controller |
| fifo_empty_in | input | 1 | Data FIFO empty flag |
| byte_stb | input | 1 | One byte moved |
| dma_conflict_in | input | 1 | DMA conflict pulse |
| dma_buserr_in | input | 1 | DMA bus error pulse |
| irq_out | output | 1 | Combined interrupt |
| fifo_rst_out | output | 1 | FIFO reset, active high |
| scsi_rst_out | output | 1 | SCSI controller reset, active high |
| dma_en_out | output | 1 | DMA engine enable |
| send_out | output | 1 | Direction, 1 = send to SCSI |

## Verification
The bound checker watches, on every cycle, the following rules: the interrupt never fires without enable, a controller-only interrupt implies DMA enabled with empty FIFO and zero count, each qualified strobe lowers the count by exactly one, FIFO count writes mirror into the DMA length, error flags stay sticky, and flags stay clear while the FIFO is held in reset. Only the directed scenarios show the concrete values. These are the register map and readback latency, the borrow across count halves, the write beating a same-cycle strobe, the count holding at zero, and the interrupt rising or staying low under each gating condition.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int AW = 3;
  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_CSR     = 3'd0;
  localparam addr_t A_ADDR_HI = 3'd1;
  localparam addr_t A_ADDR_LO = 3'd2;
  localparam addr_t A_DCNT_HI = 3'd3;
  localparam addr_t A_DCNT_LO = 3'd4;
  localparam addr_t A_FCNT_HI = 3'd5;
  localparam addr_t A_FCNT_LO = 3'd6;
  localparam addr_t A_IVAM    = 3'd7;

  localparam int B_FIFO_RSTN = 0;
  localparam int B_SCSI_RSTN = 1;
  localparam int B_IEN       = 2;
  localparam int B_DMA_EN    = 3;
  localparam int B_SEND      = 4;
  localparam int B_SBC_IP    = 8;
  localparam int B_DMA_IP    = 9;
  localparam int B_CONFLICT  = 10;
  localparam int B_BUSERR    = 11;
  localparam int CTL_BITS    = 5;
endpackage

// File: rtl/dma_csr_count.sv
module dma_csr_count #(
  parameter int  HW      = 16,
  parameter bit  HAS_DEC = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [HW-1:0]   wdata,
  input  logic            dec,
  output logic [2*HW-1:0] cnt
);
  localparam int CW = 2 * HW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) cnt[CW-1:HW] <= wdata;
      if (wr_lo) cnt[HW-1:0]  <= wdata;
    end else if (HAS_DEC && dec) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_csr,
  input  logic [CTL_BITS-1:0] ctl_wdata,
  input  logic                sbc_irq_in,
  input  logic                conflict_in,
  input  logic                buserr_in,
  input  logic                zero_hit,
  output logic                fifo_rst_n,
  output logic                scsi_rst_n,
  output logic                ien,
  output logic                dma_en,
  output logic                send,
  output logic                sbc_ip,
  output logic                dma_ip,
  output logic                err_conf,
  output logic                err_berr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_rst_n <= 1'b0;
      scsi_rst_n <= 1'b0;
      ien        <= 1'b0;
      dma_en     <= 1'b0;
      send       <= 1'b0;
      sbc_ip     <= 1'b0;
      dma_ip     <= 1'b0;
      err_conf   <= 1'b0;
      err_berr   <= 1'b0;
    end else begin
      if (wr_csr) begin
        fifo_rst_n <= ctl_wdata[B_FIFO_RSTN];
        scsi_rst_n <= ctl_wdata[B_SCSI_RSTN];
        ien        <= ctl_wdata[B_IEN];
        dma_en     <= ctl_wdata[B_DMA_EN];
        send       <= ctl_wdata[B_SEND];
      end
      sbc_ip <= sbc_irq_in;
      if (!fifo_rst_n) begin
        dma_ip   <= 1'b0;
        err_conf <= 1'b0;
        err_berr <= 1'b0;
      end else begin
        if (zero_hit)    dma_ip   <= 1'b1;
        if (conflict_in) err_conf <= 1'b1;
        if (buserr_in)   err_berr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq (
  input  logic clk,
  input  logic rst,
  input  logic ien,
  input  logic dma_en,
  input  logic sbc_ip,
  input  logic fifo_empty,
  input  logic cnt_zero,
  input  logic dma_ip,
  input  logic err_conf,
  input  logic err_berr,
  output logic irq
);
  logic sbc_pass;
  logic dma_side;

  always_comb begin
    sbc_pass = sbc_ip && dma_en && fifo_empty && cnt_zero;
    dma_side = dma_ip || err_conf || err_berr;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ien && (sbc_pass || dma_side);
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sbc_irq_in,
  input  logic          fifo_empty_in,
  input  logic          byte_stb,
  input  logic          dma_conflict_in,
  input  logic          dma_buserr_in,
  output logic          irq_out,
  output logic          fifo_rst_out,
  output logic          scsi_rst_out,
  output logic          dma_en_out,
  output logic          send_out
);
  localparam int CW = 2 * DW;

  logic          f_rst_n, s_rst_n, ien, dma_en, send;
  logic          sbc_ip, dma_ip, err_conf, err_berr;
  logic [CW-1:0] fifo_cnt, dma_cnt, dma_addr;
  logic [DW-1:0] ivam;
  logic [DW-1:0] csr_word;
  logic          wr_csr, wr_fhi, wr_flo, wr_dhi, wr_dlo, wr_ahi, wr_alo;
  logic          cnt_zero, dec, zero_hit;

  always_comb begin
    wr_csr   = reg_wr && (reg_addr == A_CSR);
    wr_ahi   = reg_wr && (reg_addr == A_ADDR_HI);
    wr_alo   = reg_wr && (reg_addr == A_ADDR_LO);
    wr_dhi   = reg_wr && (reg_addr == A_DCNT_HI);
    wr_dlo   = reg_wr && (reg_addr == A_DCNT_LO);
    wr_fhi   = reg_wr && (reg_addr == A_FCNT_HI);
    wr_flo   = reg_wr && (reg_addr == A_FCNT_LO);
    cnt_zero = (fifo_cnt == '0);
    dec      = byte_stb && dma_en && f_rst_n && !cnt_zero;
    zero_hit = dec && (fifo_cnt == CW'(1)) && !wr_fhi && !wr_flo;
  end

  dma_csr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_csr(wr_csr),
    .ctl_wdata(reg_wdata[CTL_BITS-1:0]),
    .sbc_irq_in(sbc_irq_in), .conflict_in(dma_conflict_in),
    .buserr_in(dma_buserr_in), .zero_hit(zero_hit),
    .fifo_rst_n(f_rst_n), .scsi_rst_n(s_rst_n), .ien(ien),
    .dma_en(dma_en), .send(send), .sbc_ip(sbc_ip), .dma_ip(dma_ip),
    .err_conf(err_conf), .err_berr(err_berr)
  );

  dma_csr_count #(.HW(DW), .HAS_DEC(1'b1)) u_fifo_cnt (
    .clk(clk), .rst(rst), .wr_hi(wr_fhi), .wr_lo(wr_flo),
    .wdata(reg_wdata), .dec(dec), .cnt(fifo_cnt)
  );

  dma_csr_count #(.HW(DW), .HAS_DEC(1'b0)) u_dma_cnt (
    .clk(clk), .rst(rst), .wr_hi(wr_dhi || wr_fhi), .wr_lo(wr_dlo || wr_flo),
    .wdata(reg_wdata), .dec(1'b0), .cnt(dma_cnt)
  );

  dma_csr_count #(.HW(DW), .HAS_DEC(1'b0)) u_dma_addr (
    .clk(clk), .rst(rst), .wr_hi(wr_ahi), .wr_lo(wr_alo),
    .wdata(reg_wdata), .dec(1'b0), .cnt(dma_addr)
  );

  dma_csr_irq u_irq (
    .clk(clk), .rst(rst), .ien(ien), .dma_en(dma_en), .sbc_ip(sbc_ip),
    .fifo_empty(fifo_empty_in), .cnt_zero(cnt_zero), .dma_ip(dma_ip),
    .err_conf(err_conf), .err_berr(err_berr), .irq(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst)        ivam <= '0;
    else if (reg_wr && (reg_addr == A_IVAM)) ivam <= reg_wdata;
  end

  always_comb begin
    csr_word              = '0;
    csr_word[B_FIFO_RSTN] = f_rst_n;
    csr_word[B_SCSI_RSTN] = s_rst_n;
    csr_word[B_IEN]       = ien;
    csr_word[B_DMA_EN]    = dma_en;
    csr_word[B_SEND]      = send;
    csr_word[B_SBC_IP]    = sbc_ip;
    csr_word[B_DMA_IP]    = dma_ip;
    csr_word[B_CONFLICT]  = err_conf;
    csr_word[B_BUSERR]    = err_berr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CSR:     reg_rdata <= csr_word;
        A_ADDR_HI: reg_rdata <= dma_addr[CW-1:DW];
        A_ADDR_LO: reg_rdata <= dma_addr[DW-1:0];
        A_DCNT_HI: reg_rdata <= dma_cnt[CW-1:DW];
        A_DCNT_LO: reg_rdata <= dma_cnt[DW-1:0];
        A_FCNT_HI: reg_rdata <= fifo_cnt[CW-1:DW];
        A_FCNT_LO: reg_rdata <= fifo_cnt[DW-1:0];
        default:   reg_rdata <= ivam;
      endcase
    end
  end

  assign fifo_rst_out = !f_rst_n;
  assign scsi_rst_out = !s_rst_n;
  assign dma_en_out   = dma_en;
  assign send_out     = send;
endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk
  import dma_csr_pkg::*;
#(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            byte_stb,
  input logic            dma_conflict_in,
  input logic            fifo_empty_in,
  input logic            irq_out,
  input logic            scsi_rst_out,
  input logic [2*DW-1:0] fifo_cnt,
  input logic [2*DW-1:0] dma_cnt,
  input logic            f_rst_n,
  input logic            ien,
  input logic            dma_en,
  input logic            dma_ip,
  input logic            err_conf,
  input logic            err_berr
);
  localparam int CW = 2 * DW;

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(ien));

  p_sbc_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !$past(dma_ip || err_conf || err_berr)) |->
      ($past(dma_en) && ($past(fifo_cnt) == '0) && $past(fifo_empty_in)));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && dma_en && f_rst_n && (fifo_cnt != '0) &&
     !(reg_wr && ((reg_addr == A_FCNT_HI) || (reg_addr == A_FCNT_LO))))
      |=> (fifo_cnt == $past(fifo_cnt) - CW'(1)));

  p_fifo_mirror_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == A_FCNT_LO)) |=> (dma_cnt[DW-1:0] == $past(reg_wdata)));

  p_conflict_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (dma_conflict_in && f_rst_n) |=> err_conf);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (err_conf && f_rst_n) |=> err_conf);

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !f_rst_n |=> (!dma_ip && !err_conf && !err_berr));

  p_scsi_reset_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == A_CSR) && !reg_wdata[B_SCSI_RSTN]) |=> scsi_rst_out);
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .byte_stb(byte_stb),
  .dma_conflict_in(dma_conflict_in), .fifo_empty_in(fifo_empty_in),
  .irq_out(irq_out), .scsi_rst_out(scsi_rst_out), .fifo_cnt(fifo_cnt),
  .dma_cnt(dma_cnt), .f_rst_n(f_rst_n), .ien(ien), .dma_en(dma_en),
  .dma_ip(dma_ip), .err_conf(err_conf), .err_berr(err_berr)
);

// File: tb/dma_csr_bank_tb.sv
module dma_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        sbc_irq_in, fifo_empty_in, byte_stb, dma_conflict_in, dma_buserr_in;
  logic        irq_out, fifo_rst_out, scsi_rst_out, dma_en_out, send_out;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  dma_csr_bank u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sbc_irq_in(sbc_irq_in),
    .fifo_empty_in(fifo_empty_in), .byte_stb(byte_stb),
    .dma_conflict_in(dma_conflict_in), .dma_buserr_in(dma_buserr_in),
    .irq_out(irq_out), .fifo_rst_out(fifo_rst_out), .scsi_rst_out(scsi_rst_out),
    .dma_en_out(dma_en_out), .send_out(send_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    @(negedge clk);
    byte_stb = 1'b1;
    repeat (n) @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 fifo_rst_out", fifo_rst_out, 1);
    check("R1 scsi_rst_out", scsi_rst_out, 1);
    check("R1 dma_en_out", dma_en_out, 0);
    check("R1 irq_out", irq_out, 0);
    rd(3'd0, v); check("R1 csr", v, 0);
    rd(3'd6, v); check("R1 fifo lo", v, 0);
    rd(3'd7, v); check("R1 vector", v, 0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(3'd1, 16'h00AB); wr(3'd2, 16'h1234); wr(3'd7, 16'h3D5A); wr(3'd3, 16'h0002);
    rd(3'd1, v); check("R2 addr hi", v, 16'h00AB);
    rd(3'd2, v); check("R2 addr lo", v, 16'h1234);
    rd(3'd7, v); check("R2 vector", v, 16'h3D5A);
    rd(3'd3, v); check("R2 dma len hi", v, 16'h0002);
    rd(3'd5, v); check("R3 fifo hi untouched by dma len write", v, 0);
    wr(3'd5, 16'h0000); wr(3'd6, 16'h0003);
    rd(3'd4, v); check("R3 dma len lo mirrors fifo write", v, 16'h0003);
    rd(3'd3, v); check("R3 dma len hi mirrors fifo write", v, 16'h0000);
  endtask

  task automatic t_rst_bits;
    wr(3'd0, 16'h0001);
    check("R4 fifo released", fifo_rst_out, 0);
    check("R4 scsi held", scsi_rst_out, 1);
    wr(3'd0, 16'h0002);
    check("R4 fifo held", fifo_rst_out, 1);
    check("R4 scsi released", scsi_rst_out, 0);
    wr(3'd0, 16'h0013);
    check("R4 send_out", send_out, 1);
    check("R4 dma_en_out off", dma_en_out, 0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr(3'd0, 16'h000F);
    check("R4 dma_en_out", dma_en_out, 1);
    strobe(2);
    rd(3'd6, v); check("R5 count after two strobes", v, 1);
    rd(3'd0, v); check("R6 no done flag yet", v, 16'h000F);
    strobe(1);
    rd(3'd6, v); check("R5 count at zero", v, 0);
    rd(3'd0, v); check("R6 done flag set", v, 16'h020F);
    check("R9 irq from done", irq_out, 1);
    strobe(2);
    rd(3'd6, v); check("R5 count holds at zero", v, 0);
    rd(3'd5, v); check("R5 no wrap on hi", v, 0);
    rd(3'd4, v); check("R3 dma len not counted", v, 3);
    @(negedge clk);
    reg_addr = 3'd6; reg_wdata = 16'h0009; reg_wr = 1'b1; byte_stb = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; byte_stb = 1'b0;
    rd(3'd6, v); check("R5 write beats strobe", v, 9);
    wr(3'd5, 16'h0001); wr(3'd6, 16'h0000);
    strobe(1);
    rd(3'd5, v); check("R5 borrow hi", v, 0);
    rd(3'd6, v); check("R5 borrow lo", v, 16'hFFFF);
    wr(3'd0, 16'h0007);
    strobe(1);
    rd(3'd6, v); check("R5 no count with dma off", v, 16'hFFFF);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    wr(3'd0, 16'h000E);
    idle(2);
    rd(3'd0, v); check("R8 flags cleared", v, 16'h000E);
    dma_conflict_in = 1'b1; idle(1); dma_conflict_in = 1'b0;
    idle(2);
    rd(3'd0, v); check("R8 conflict ignored while held", v, 16'h000E);
    check("R9 no irq after clear", irq_out, 0);
  endtask

  task automatic t_errors;
    logic [15:0] v;
    wr(3'd0, 16'h000F);
    dma_conflict_in = 1'b1; idle(1); dma_conflict_in = 1'b0;
    idle(2);
    rd(3'd0, v); check("R7 conflict flag", v, 16'h040F);
    check("R9 irq from conflict", irq_out, 1);
    idle(5);
    rd(3'd0, v); check("R7 conflict sticky", v, 16'h040F);
    wr(3'd0, 16'h000E); wr(3'd0, 16'h000B);
    dma_buserr_in = 1'b1; idle(1); dma_buserr_in = 1'b0;
    idle(2);
    rd(3'd0, v); check("R7 bus error flag", v, 16'h080B);
    check("R9 irq masked by enable", irq_out, 0);
  endtask

  task automatic t_sbc;
    logic [15:0] v;
    wr(3'd5, 16'h0000); wr(3'd6, 16'h0000);
    wr(3'd0, 16'h000E); wr(3'd0, 16'h000F);
    fifo_empty_in = 1'b1; sbc_irq_in = 1'b1;
    idle(3);
    check("R10 sbc irq passes", irq_out, 1);
    rd(3'd0, v); check("R7 sbc pending bit", v, 16'h010F);
    wr(3'd0, 16'h0007); idle(3);
    check("R10 gated by dma enable", irq_out, 0);
    wr(3'd0, 16'h000F); fifo_empty_in = 1'b0; idle(3);
    check("R10 gated by fifo not empty", irq_out, 0);
    fifo_empty_in = 1'b1; wr(3'd6, 16'h0005); idle(3);
    check("R10 gated by nonzero count", irq_out, 0);
    wr(3'd6, 16'h0000); idle(3);
    check("R10 passes again", irq_out, 1);
    sbc_irq_in = 1'b0; idle(3);
    check("R9 irq drops", irq_out, 0);
  endtask

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    sbc_irq_in = 1'b0; fifo_empty_in = 1'b0; byte_stb = 1'b0;
    dma_conflict_in = 1'b0; dma_buserr_in = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regs();
    t_rst_bits();
    t_count();
    t_clear();
    t_errors();
    t_sbc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule